// File: doc/BRIEF.md
# Shared Transmit/Receive Descriptor Ring Manager

This block owns one table of buffer descriptors that transmit and receive share. Each entry has two 32-bit words: a length-and-flags word, then a buffer address. A programmable boundary register divides the table. Entries below the boundary form the transmit ring and entries from the boundary up to the last index form the receive ring. The host reaches the table through a 1 KB window. Byte-address bits [9:3] select the entry and bit 2 selects the word.

The block keeps the current transmit and receive indexes. It decides when a transmit may begin and exposes the current descriptor of each ring to the frame movers outside it. When a frame finishes, the block writes the status back into the descriptor and advances the ring. Completions arrive on valid/ready handshakes, and a receive completion carries the final length and status. Three interrupt sources (transmit done, receive done, receive busy) are combined with a mask into a single interrupt line.

Top module: `bd_ring_mgr`

## Requirements
- R1: A host write to the window stores the data into word `addr[2]` (0 = length/flags, 1 = buffer address) of entry `addr[9:3]`. `dwin_rdata` returns that word combinationally for the address on `dwin_addr`.
- R2: The boundary register resets to 0x40. A write of a value of 0x80 or more leaves it unchanged, and any smaller value is stored.
- R3: After reset the transmit index is 0 and the receive index is 0x40. A rising edge of `tx_enable` sets the transmit index to 0, and a rising edge of `rx_enable` sets the receive index to the boundary value.
- R4: A start check runs in the cycle after a host window write or a rising edge of `tx_enable`. A start needs all of the following: transmit enabled, boundary nonzero, ready bit 15 of the current descriptor set, and length bits [31:16] greater than 4. When a start happens, `tx_start` pulses for one cycle and `tx_busy` rises on the same edge.
- R5: While `tx_busy` is high, no new start occurs, and the block never retries a check on its own.
- R6: An accepted transmit completion sets the transmit index to 0 when wrap bit 13 is set. Otherwise the index increments and returns to 0 on reaching the boundary.
- R7: An accepted transmit completion clears bits 15, 8 and 7:0 of the descriptor's first word and keeps all other bits. It also drops `tx_busy`.
- R8: An accepted receive completion on a descriptor whose empty bit 15 is clear sets interrupt source bit 4. It leaves the descriptor and the receive index unchanged.
- R9: An accepted receive completion on a descriptor whose empty bit is set writes {length, 0, old bits 14:9, status[8:0]} into the first word. The index then moves to the boundary if wrap bit 13 is set or the index is 127, and increments otherwise.
- R10: A completed descriptor with bit 14 set raises interrupt source bit 0 (transmit) or bit 2 (receive).
- R11: A source-clear write clears the source bits written as 1. `irq` is the OR of source AND mask at all times, and a mask write takes effect on the next cycle.
- R12: `rx_ready` is high only when receive is enabled and the boundary is below 0x80. A receive completion accepted while `rx_ready` is low has no effect.
- R13: Table write priority is host, then receive, then transmit. `rx_done_ready` is low during a host write, and `tx_done_ready` is low during a host write or while `rx_done_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dwin_we | input | 1 | Descriptor window write strobe |
| dwin_addr | input | 10 | Window byte address |
| dwin_wdata | input | 32 | Window write data |
| dwin_rdata | output | 32 | Window read data (combinational) |
| split_we | input | 1 | Boundary register write strobe |
| split_wdata | input | 8 | Boundary write value |
| split_q | output | 8 | Current boundary |
| tx_enable | input | 1 | Transmit enable mode bit |
| rx_enable | input | 1 | Receive enable mode bit |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 5 | Interrupt mask value |
| src_clr_we | input | 1 | Source-clear write strobe |
| src_clr_data | input | 5 | Source bits to clear |
| int_src | output | 5 | Interrupt source register |
| irq | output | 1 | Interrupt line |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_busy | output | 1 | Transmit in flight |
| tx_idx | output | 7 | Current transmit index |
| tx_len | output | 16 | Length of current transmit descriptor |
| tx_buf | output | 32 | Buffer address of current transmit descriptor |
| tx_done_valid | input | 1 | Transmit completion valid |
| tx_done_ready | output | 1 | Transmit completion accepted |
| rx_ready | output | 1 | Receive allowed |
| rx_idx | output | 7 | Current receive index |
| rx_buf | output | 32 | Buffer address of current receive descriptor |
| rx_done_valid | input | 1 | Receive completion valid |
| rx_done_len | input | 16 | Final received length |
| rx_done_stat | input | 9 | Receive status bits |
| rx_done_ready | output | 1 | Receive completion accepted |

## Verification
The assertions assume three things about the inputs. A transmit completion is offered only while a transmit is in flight. A completion's effect on the index depends only on the wrap bit and boundary present in the same cycle. The boundary changes only through its write strobe. The stimulus follows these assumptions: it raises `tx_done_valid` only after a `tx_start` has been observed, and it never changes the boundary or the enables in the cycle a completion is handshaked. One exception is deliberate. A single arbitration step holds a host write and a receive completion together, so the ready outputs can be checked at the moment of contention.

// File: rtl/bd_pkg.sv
// Package: shared constants for the descriptor ring manager.
// Holds descriptor bit positions and interrupt source bit positions.
package bd_pkg;
    localparam int LEN_LSB    = 16;  // length field [31:16]
    localparam int BIT_RDY    = 15;  // ready (tx) / empty (rx)
    localparam int BIT_IRQ    = 14;  // raise interrupt on completion
    localparam int BIT_WRAP   = 13;  // ring wraps after this entry
    localparam int SRC_W      = 5;   // interrupt source width
    localparam int SRC_TXB    = 0;
    localparam int SRC_RXB    = 2;
    localparam int SRC_BUSY   = 4;
    localparam logic [31:0] TX_CLR_MASK = 32'h0000_81FF;
    localparam int MIN_TX_LEN = 4;
endpackage

// File: rtl/bd_table.sv
// Module: descriptor storage. NUM_BD entries of two DW-bit words.
// Has one write port and three combinational read ports (host, tx, rx).
// Assumes the parent arbitrates so that only one writer is active per cycle.
module bd_table #(
    parameter int NUM_BD = 128,
    parameter int DW     = 32,
    localparam int IDX_W = $clog2(NUM_BD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic             wsel_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IDX_W-1:0] hidx_i,
    input  logic             hsel_i,
    output logic [DW-1:0]    hdata_o,
    input  logic [IDX_W-1:0] tidx_i,
    output logic [DW-1:0]    tlf_o,
    output logic [DW-1:0]    tbuf_o,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [DW-1:0]    rlf_o,
    output logic [DW-1:0]    rbuf_o
);
    logic [DW-1:0] lf_mem  [NUM_BD];
    logic [DW-1:0] buf_mem [NUM_BD];

    // Storage update: clear on reset, single write port otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BD; i++) begin
                lf_mem[i]  <= '0;
                buf_mem[i] <= '0;
            end
        end else if (we_i) begin
            if (wsel_i) buf_mem[widx_i] <= wdata_i;
            else        lf_mem[widx_i]  <= wdata_i;
        end
    end

    // Read ports: combinational lookups.
    always_comb begin
        hdata_o = hsel_i ? buf_mem[hidx_i] : lf_mem[hidx_i];
        tlf_o   = lf_mem[tidx_i];
        tbuf_o  = buf_mem[tidx_i];
        rlf_o   = lf_mem[ridx_i];
        rbuf_o  = buf_mem[ridx_i];
    end
endmodule

// File: rtl/bd_tx_ctrl.sv
// Module: transmit ring control. Keeps the transmit index, runs the start
// check one cycle after a trigger, and tracks the single in-flight frame.
// It also forms the status write-back. Assumes done_i is offered only while busy.
module bd_tx_ctrl
    import bd_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int SPL_W = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en_i,
    input  logic [SPL_W-1:0] split_i,
    input  logic             host_wr_i,
    input  logic [DW-1:0]    lf_i,
    input  logic             done_i,
    output logic [IDX_W-1:0] ptr_o,
    output logic             busy_o,
    output logic             start_o,
    output logic             wb_en_o,
    output logic [DW-1:0]    wb_data_o,
    output logic             set_txb_o
);
    logic             en_q, chk_q, busy_q, start_q;
    logic [IDX_W-1:0] ptr_q;
    logic             rise, can_go, fire;
    logic [SPL_W-1:0] nxt;

    // Start decision and completion decode.
    always_comb begin
        rise      = tx_en_i & ~en_q;
        can_go    = chk_q && !busy_q && tx_en_i && (split_i != '0) &&
                    lf_i[BIT_RDY] && (lf_i[DW-1:LEN_LSB] > (DW-LEN_LSB)'(MIN_TX_LEN));
        fire      = done_i && busy_q;
        nxt       = SPL_W'(ptr_q) + SPL_W'(1);
        wb_en_o   = fire;
        wb_data_o = lf_i & ~TX_CLR_MASK;
        set_txb_o = fire && lf_i[BIT_IRQ];
    end

    // State: edge detect, check trigger, busy flag and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; chk_q <= 1'b0; busy_q <= 1'b0; start_q <= 1'b0;
            ptr_q <= '0;
        end else begin
            en_q    <= tx_en_i;
            chk_q   <= host_wr_i | rise;
            start_q <= can_go;
            if (can_go)    busy_q <= 1'b1;
            else if (fire) busy_q <= 1'b0;
            if (rise)
                ptr_q <= '0;
            else if (fire)
                ptr_q <= (lf_i[BIT_WRAP] || nxt >= split_i) ? '0 : nxt[IDX_W-1:0];
        end
    end

    assign ptr_o   = ptr_q;
    assign busy_o  = busy_q;
    assign start_o = start_q;

    // R4: a start pulse always coincides with busy becoming set
    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (busy_q && !$past(busy_q)));
    // R5: no start while a frame was already in flight
    a_r5_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fire) |=> !start_q);
    // R6: completion without wrap either steps or returns to zero
    a_r6_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !lf_i[BIT_WRAP]) |=> (ptr_q == '0 || ptr_q == $past(ptr_q) + 1'b1));
    // R6: completion with wrap returns to zero
    a_r6_tx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && lf_i[BIT_WRAP]) |=> ptr_q == '0);
endmodule

// File: rtl/bd_rx_ctrl.sv
// Module: receive ring control. Keeps the receive index, checks the empty
// bit on each completion and forms the status write-back or the busy event.
// Assumes fire_i is the accepted completion handshake.
module bd_rx_ctrl
    import bd_pkg::*;
#(
    parameter int NUM_BD    = 128,
    parameter int SPL_W     = 8,
    parameter int DW        = 32,
    parameter int SPLIT_RST = 64,
    localparam int IDX_W    = $clog2(NUM_BD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en_i,
    input  logic [SPL_W-1:0] split_i,
    input  logic [DW-1:0]    lf_i,
    input  logic             fire_i,
    input  logic [15:0]      len_i,
    input  logic [8:0]       stat_i,
    output logic             ok_o,
    output logic [IDX_W-1:0] ptr_o,
    output logic             wb_en_o,
    output logic [DW-1:0]    wb_data_o,
    output logic             set_rxb_o,
    output logic             set_busy_o
);
    logic             en_q, rise, take, has_room;
    logic [IDX_W-1:0] ptr_q;

    // Completion decode and write-back word.
    always_comb begin
        ok_o       = rx_en_i && (split_i < SPL_W'(NUM_BD));
        rise       = rx_en_i & ~en_q;
        take       = fire_i && ok_o;
        has_room   = lf_i[BIT_RDY];
        wb_en_o    = take && has_room;
        set_busy_o = take && !has_room;
        set_rxb_o  = take && has_room && lf_i[BIT_IRQ];
        wb_data_o  = {len_i, 1'b0, lf_i[14:9], stat_i};
    end

    // Index update: enable edge reloads, completion advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ptr_q <= IDX_W'(SPLIT_RST);
        end else begin
            en_q <= rx_en_i;
            if (rise)
                ptr_q <= split_i[IDX_W-1:0];
            else if (take && has_room)
                ptr_q <= (lf_i[BIT_WRAP] || ptr_q == IDX_W'(NUM_BD-1))
                         ? split_i[IDX_W-1:0] : ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    // R8: a dropped frame leaves the receive index where it was
    a_r8_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !has_room && !rise) |=> $stable(ptr_q));
    // R9: an accepted frame moves the index to the boundary or one step on
    a_r9_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && has_room) |=> (ptr_q == $past(split_i[IDX_W-1:0]) ||
                                ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/bd_irq.sv
// Module: interrupt source and mask registers. Sources are set by events
// and cleared by write-one; the line is the OR of source AND mask.
// Assumes a set and a clear of the same bit in one cycle resolves to set.
module bd_irq
    import bd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_i,
    input  logic             clr_we_i,
    input  logic [SRC_W-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic [SRC_W-1:0] src_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] src_q, mask_q;

    // Source and mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            mask_q <= '0;
        end else begin
            src_q <= (src_q & ~(clr_we_i ? clr_i : '0)) | set_i;
            if (mask_we_i) mask_q <= mask_i;
        end
    end

    assign src_o = src_q;
    assign irq_o = |(src_q & mask_q);

    // R11: cleared bits read back as zero unless set again
    a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && set_i == '0) |=> ((src_q & $past(clr_i)) == '0));
    // R10: an event is visible in the source register on the next cycle
    a_r10_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/bd_ring_mgr.sv
// Module: top of the shared descriptor ring manager. Holds the boundary
// register and arbitrates the table write port (host > rx > tx).
// It connects the transmit, receive and interrupt controllers.
// Assumes dwin_addr is a byte address inside a 1 KB window.
module bd_ring_mgr
    import bd_pkg::*;
#(
    parameter int NUM_BD    = 128,
    parameter int DW        = 32,
    parameter int SPLIT_RST = 64,
    localparam int IDX_W    = $clog2(NUM_BD),
    localparam int SPL_W    = IDX_W + 1,
    localparam int AW       = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dwin_we,
    input  logic [AW-1:0]    dwin_addr,
    input  logic [DW-1:0]    dwin_wdata,
    output logic [DW-1:0]    dwin_rdata,
    input  logic             split_we,
    input  logic [SPL_W-1:0] split_wdata,
    output logic [SPL_W-1:0] split_q,
    input  logic             tx_enable,
    input  logic             rx_enable,
    input  logic             mask_we,
    input  logic [SRC_W-1:0] mask_wdata,
    input  logic             src_clr_we,
    input  logic [SRC_W-1:0] src_clr_data,
    output logic [SRC_W-1:0] int_src,
    output logic             irq,
    output logic             tx_start,
    output logic             tx_busy,
    output logic [IDX_W-1:0] tx_idx,
    output logic [15:0]      tx_len,
    output logic [DW-1:0]    tx_buf,
    input  logic             tx_done_valid,
    output logic             tx_done_ready,
    output logic             rx_ready,
    output logic [IDX_W-1:0] rx_idx,
    output logic [DW-1:0]    rx_buf,
    input  logic             rx_done_valid,
    input  logic [15:0]      rx_done_len,
    input  logic [8:0]       rx_done_stat,
    output logic             rx_done_ready
);
    logic [SPL_W-1:0] split_r;
    logic [DW-1:0]    t_lf, r_lf;
    logic             tx_wb_en, rx_wb_en, set_txb, set_rxb, set_busy;
    logic [DW-1:0]    tx_wb, rx_wb;
    logic             we;
    logic [IDX_W-1:0] widx;
    logic             wsel;
    logic [DW-1:0]    wdata;
    logic [SRC_W-1:0] set_vec;

    // Boundary register: values at or above the table size are refused.
    always_ff @(posedge clk) begin
        if (!rst_n)
            split_r <= SPL_W'(SPLIT_RST);
        else if (split_we && split_wdata < SPL_W'(NUM_BD))
            split_r <= split_wdata;
    end
    assign split_q = split_r;

    // Handshake readiness follows the fixed write-port priority.
    assign rx_done_ready = !dwin_we;
    assign tx_done_ready = !dwin_we && !rx_done_valid;

    // Write-port mux: host first, then receive, then transmit.
    always_comb begin
        we = 1'b1; widx = dwin_addr[AW-1:3]; wsel = dwin_addr[2]; wdata = dwin_wdata;
        if (!dwin_we) begin
            wsel = 1'b0;
            if (rx_wb_en) begin
                widx = rx_idx; wdata = rx_wb;
            end else begin
                we = tx_wb_en; widx = tx_idx; wdata = tx_wb;
            end
        end
    end

    bd_table #(.NUM_BD(NUM_BD), .DW(DW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we_i(we), .widx_i(widx), .wsel_i(wsel), .wdata_i(wdata),
        .hidx_i(dwin_addr[AW-1:3]), .hsel_i(dwin_addr[2]), .hdata_o(dwin_rdata),
        .tidx_i(tx_idx), .tlf_o(t_lf), .tbuf_o(tx_buf),
        .ridx_i(rx_idx), .rlf_o(r_lf), .rbuf_o(rx_buf)
    );

    bd_tx_ctrl #(.IDX_W(IDX_W), .SPL_W(SPL_W), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_enable), .split_i(split_r),
        .host_wr_i(dwin_we), .lf_i(t_lf), .done_i(tx_done_valid && tx_done_ready),
        .ptr_o(tx_idx), .busy_o(tx_busy), .start_o(tx_start),
        .wb_en_o(tx_wb_en), .wb_data_o(tx_wb), .set_txb_o(set_txb)
    );

    bd_rx_ctrl #(.NUM_BD(NUM_BD), .SPL_W(SPL_W), .DW(DW), .SPLIT_RST(SPLIT_RST)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_enable), .split_i(split_r),
        .lf_i(r_lf), .fire_i(rx_done_valid && rx_done_ready),
        .len_i(rx_done_len), .stat_i(rx_done_stat),
        .ok_o(rx_ready), .ptr_o(rx_idx), .wb_en_o(rx_wb_en), .wb_data_o(rx_wb),
        .set_rxb_o(set_rxb), .set_busy_o(set_busy)
    );

    // Event vector into the interrupt block.
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_TXB]  = set_txb;
        set_vec[SRC_RXB]  = set_rxb;
        set_vec[SRC_BUSY] = set_busy;
    end

    bd_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec),
        .clr_we_i(src_clr_we), .clr_i(src_clr_data),
        .mask_we_i(mask_we), .mask_i(mask_wdata),
        .src_o(int_src), .irq_o(irq)
    );

    assign tx_len = t_lf[DW-1:LEN_LSB];

    // R2: the boundary never leaves the table range
    a_r2_split_range: assert property (@(posedge clk) disable iff (!rst_n)
        split_r < SPL_W'(NUM_BD));
    // R13: receive and transmit write-backs never coincide with a host write
    a_r13_host_first: assert property (@(posedge clk) disable iff (!rst_n)
        dwin_we |-> !(rx_done_valid && rx_done_ready) && !(tx_done_valid && tx_done_ready));
endmodule

// File: tb/bd_ring_mgr_bench.sv
module bd_ring_mgr_bench;
    logic        clk = 0, rst_n = 0;
    logic        dwin_we = 0;
    logic [9:0]  dwin_addr = 0;
    logic [31:0] dwin_wdata = 0, dwin_rdata;
    logic        split_we = 0;
    logic [7:0]  split_wdata = 0, split_q;
    logic        tx_enable = 0, rx_enable = 0;
    logic        mask_we = 0, src_clr_we = 0;
    logic [4:0]  mask_wdata = 0, src_clr_data = 0, int_src;
    logic        irq, tx_start, tx_busy, tx_done_valid = 0, tx_done_ready;
    logic [6:0]  tx_idx, rx_idx;
    logic [15:0] tx_len;
    logic [31:0] tx_buf, rx_buf;
    logic        rx_ready, rx_done_valid = 0, rx_done_ready;
    logic [15:0] rx_done_len = 0;
    logic [8:0]  rx_done_stat = 0;

    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    typedef struct packed {
        logic [6:0]  idx;
        logic [15:0] len;
        logic [31:0] bufa;
    } tx_item_t;
    tx_item_t exp_q[$];

    always #2 clk = ~clk;

    bd_ring_mgr u_bd_ring_mgr (
        .clk(clk), .rst_n(rst_n), .dwin_we(dwin_we), .dwin_addr(dwin_addr),
        .dwin_wdata(dwin_wdata), .dwin_rdata(dwin_rdata), .split_we(split_we),
        .split_wdata(split_wdata), .split_q(split_q), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .src_clr_we(src_clr_we), .src_clr_data(src_clr_data), .int_src(int_src),
        .irq(irq), .tx_start(tx_start), .tx_busy(tx_busy), .tx_idx(tx_idx),
        .tx_len(tx_len), .tx_buf(tx_buf), .tx_done_valid(tx_done_valid),
        .tx_done_ready(tx_done_ready), .rx_ready(rx_ready), .rx_idx(rx_idx),
        .rx_buf(rx_buf), .rx_done_valid(rx_done_valid), .rx_done_len(rx_done_len),
        .rx_done_stat(rx_done_stat), .rx_done_ready(rx_done_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every start must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && tx_start) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R4/R5 unexpected start: actual idx=%h expected none", tx_idx);
            end else begin
                tx_item_t e;
                e = exp_q.pop_front();
                if ({tx_idx, tx_len, tx_buf} !== e) begin
                    n_errors++;
                    $display("FAIL R4 start item: actual=%h expected=%h",
                             {tx_idx, tx_len, tx_buf}, e);
                end
            end
        end
    end

    task automatic expect_start(input logic [6:0] i, input logic [15:0] l, input logic [31:0] b);
        exp_q.push_back({i, l, b});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk); dwin_we = 1; dwin_addr = a; dwin_wdata = d;
        @(negedge clk); dwin_we = 0;
        idle(2);
    endtask

    task automatic hrd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk); dwin_addr = a; #1 d = dwin_rdata;
    endtask

    task automatic set_split(input logic [7:0] v);
        @(negedge clk); split_we = 1; split_wdata = v;
        @(negedge clk); split_we = 0;
    endtask

    task automatic tx_done();
        @(negedge clk); tx_done_valid = 1;
        @(negedge clk); tx_done_valid = 0;
    endtask

    task automatic rx_done(input logic [15:0] l, input logic [8:0] s);
        @(negedge clk); rx_done_valid = 1; rx_done_len = l; rx_done_stat = s;
        @(negedge clk); rx_done_valid = 0;
    endtask

    task automatic clr_src(input logic [4:0] v);
        @(negedge clk); src_clr_we = 1; src_clr_data = v;
        @(negedge clk); src_clr_we = 0;
    endtask

    task automatic set_mask(input logic [4:0] v);
        @(negedge clk); mask_we = 1; mask_wdata = v;
        @(negedge clk); mask_we = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3); rst_n = 1; idle(1);
        // reset state
        chk("R2 split reset", split_q, 8'h40);
        chk("R3 tx idx reset", tx_idx, 0);
        chk("R3 rx idx reset", rx_idx, 7'h40);
        chk("R11 src reset", {int_src, irq}, 0);
        chk("R12 rx_ready off", rx_ready, 0);
        chk("R4 not busy", tx_busy, 0);

        // R1 window access
        hwr(10'h028, 32'h1234_5678);
        hwr(10'h02C, 32'h9ABC_DEF0);
        hrd(10'h028, d); chk("R1 word0 readback", d, 32'h1234_5678);
        hrd(10'h02C, d); chk("R1 word1 readback", d, 32'h9ABC_DEF0);

        // R2 boundary writes
        set_split(8'h80); chk("R2 high write ignored", split_q, 8'h40);
        set_split(8'h03); chk("R2 write stored", split_q, 8'h03);
        set_mask(5'h15);

        // R4 first transmit
        @(negedge clk); tx_enable = 1; idle(3);
        hwr(10'h004, 32'hA000_0000);
        expect_start(0, 16'd60, 32'hA000_0000);
        hwr(10'h000, 32'h003C_D1FF);
        chk("R4 busy after start", tx_busy, 1);
        // R5 suppressed while busy
        hwr(10'h00C, 32'hB000_0000);
        hwr(10'h008, 32'h000A_8000);
        tx_done();
        hrd(10'h000, d); chk("R7 status cleared", d, 32'h003C_5000);
        chk("R6 index step", tx_idx, 1);
        chk("R10 txb source", int_src[0], 1);
        chk("R11 irq follows mask", irq, 1);
        chk("R7 busy drops", tx_busy, 0);
        chk("R5 no start pending", exp_q.size(), 0);

        // second transmit after re-check
        expect_start(1, 16'd10, 32'hB000_0000);
        hwr(10'h008, 32'h000A_8000);
        tx_done();
        chk("R6 index step 2", tx_idx, 2);

        // R4 length boundary, then R6 boundary wrap
        hwr(10'h014, 32'hC000_0000);
        hwr(10'h010, 32'h0004_8000);
        chk("R4 length 4 refused", tx_busy, 0);
        expect_start(2, 16'd5, 32'hC000_0000);
        hwr(10'h010, 32'h0005_8000);
        tx_done();
        chk("R6 wrap at boundary", tx_idx, 0);

        // R6 wrap bit
        expect_start(0, 16'd20, 32'hA000_0000);
        hwr(10'h000, 32'h0014_A000);
        tx_done();
        chk("R6 wrap bit to zero", tx_idx, 0);

        // R3 enable edge resets tx index
        expect_start(0, 16'd20, 32'hA000_0000);
        hwr(10'h000, 32'h0014_8000);
        tx_done();
        chk("R6 step before toggle", tx_idx, 1);
        @(negedge clk); tx_enable = 0; idle(2);
        @(negedge clk); tx_enable = 1; idle(3);
        chk("R3 tx rise resets", tx_idx, 0);

        // R4 boundary zero blocks
        set_split(8'h00);
        hwr(10'h000, 32'h0014_8000);
        chk("R4 split zero refused", tx_busy, 0);
        hwr(10'h000, 32'h0000_0000);

        // Receive
        set_split(8'h10);
        clr_src(5'h1F);
        chk("R11 clear all", {int_src, irq}, 0);
        rx_done(16'd9, 9'h001);
        chk("R12 ignored idx", rx_idx, 7'h40);
        chk("R12 ignored src", int_src, 0);
        @(negedge clk); rx_enable = 1; idle(2);
        chk("R3 rx rise loads split", rx_idx, 7'h10);
        chk("R12 rx_ready on", rx_ready, 1);

        rx_done(16'd50, 9'h003);
        chk("R8 busy source", int_src, 5'h10);
        chk("R8 index held", rx_idx, 7'h10);
        hrd(10'h080, d); chk("R8 descriptor untouched", d, 0);
        chk("R11 irq via mask", irq, 1);
        set_mask(5'h05); idle(1);
        chk("R11 masked off", irq, 0);
        set_mask(5'h15);

        hwr(10'h084, 32'hD000_0000);
        hwr(10'h080, 32'h0000_C0FF);
        chk("R1 rx buffer out", rx_buf, 32'hD000_0000);
        rx_done(16'd100, 9'h0A5);
        hrd(10'h080, d); chk("R9 write-back", d, 32'h0064_40A5);
        chk("R9 index step", rx_idx, 7'h11);
        chk("R10 rxb source", int_src, 5'h14);

        hwr(10'h088, 32'h0000_A000);
        rx_done(16'd7, 9'h000);
        hrd(10'h088, d); chk("R9 wrap write-back", d, 32'h0007_2000);
        chk("R9 wrap bit to split", rx_idx, 7'h10);

        set_split(8'h7F);
        @(negedge clk); rx_enable = 0; idle(2);
        @(negedge clk); rx_enable = 1; idle(2);
        chk("R3 rx reload 127", rx_idx, 7'h7F);
        set_split(8'h10);
        hwr(10'h3F8, 32'h0000_8000);
        rx_done(16'd1, 9'h001);
        hrd(10'h3F8, d); chk("R9 last entry write-back", d, 32'h0001_0001);
        chk("R9 last entry wraps", rx_idx, 7'h10);

        clr_src(5'h04);
        chk("R11 partial clear", int_src, 5'h10);

        // R13 arbitration
        @(negedge clk); dwin_we = 1; dwin_addr = 10'h300; dwin_wdata = 32'h1; rx_done_valid = 1;
        #1 chk("R13 rx held by host", rx_done_ready, 0);
        chk("R13 tx held by host", tx_done_ready, 0);
        @(negedge clk); dwin_we = 0;
        #1 chk("R13 rx granted", rx_done_ready, 1);
        chk("R13 tx held by rx", tx_done_ready, 0);
        @(negedge clk); rx_done_valid = 0;
        idle(3);
        chk("R5 all starts seen", exp_q.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule